// File: doc/BRIEF.md
# Round-Robin Channel Transmit Scheduler

This block feeds a single word-wide transmit queue from sixteen independent byte streams. Each channel owns a circular byte store four times as deep, in bytes, as the downstream queue is in words. Producers deposit up to four bytes at a time into a chosen channel. The block reports back how many of those bytes fit and drops the rest.

On every cycle the scheduler looks for a channel that holds data. The search starts at a rotating pointer. It offers up to four of that channel's oldest bytes to an external packer. The packer is combinational and returns a packed 32-bit word together with the number of bytes it consumed. The scheduler then pushes that word, tagged with the channel number, unless the downstream queue reports full. The pointer moves past a channel only when a word from it has been pushed, so every channel with pending data gets a turn. A per-channel flush discards a channel's pending bytes. A per-channel empty flag shows which channels still hold data.

Top module: `chan_tx_sched`

## Requirements
- R1: While `rst_ni` is low and in the first cycle after it rises, `empty_o` is all ones and `tx_push_o` is low. The rotating pointer starts at channel 0.
- R2: A write of `wr_len_i` bytes to channel `wr_ch_i` is accepted in the same cycle. `wr_len_i` values above 4 count as 4. The accepted count is the smaller of the length and the channel's free space. `wr_accept_o` reports this count. Byte lane k (`wr_data_i[8k+7:8k]`) is the k-th byte of the write, and only the first accepted lanes are stored.
- R3: `tx_push_o` is never high while `tx_full_i` is high.
- R4: After a push from channel c, the next search starts at channel c+1. The search wraps from channel 15 to channel 0. A channel that has just sent waits behind every other channel that holds data.
- R5: Channels without data are skipped. A push only ever comes from a channel whose `empty_o` bit is low.
- R6: Lane k of `pk_bytes_o` holds the k-th oldest byte of the selected channel. This holds even when those bytes straddle the wrap point of the circular store.
- R7: `pk_avail_o` equals the smaller of the selected channel's byte count and 4, and is 0 when no channel holds data. A push removes exactly `pk_used_i` bytes from that channel, effective the next cycle.
- R8: A channel's `empty_o` bit is high exactly when its byte count is zero. It is updated on the cycle after the write, push or flush that changes the count.
- R9: `flush_i[c]` empties channel c by the next cycle. The channel is not eligible for selection in the flushing cycle. The flush overrides a same-cycle write to that channel, which then reports `wr_accept_o` of 0.
- R10: During a push, `tx_ch_o` names the selected channel and `tx_word_o` carries `pk_word_i` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_valid_i | input | 1 | Producer write strobe |
| wr_ch_i | input | 4 | Channel addressed by the write |
| wr_len_i | input | 3 | Bytes offered (0 to 4) |
| wr_data_i | input | 32 | Write bytes, lane 0 first |
| wr_accept_o | output | 3 | Bytes actually stored |
| flush_i | input | 16 | Per-channel discard request |
| empty_o | output | 16 | Per-channel no-data flag |
| pk_bytes_o | output | 32 | Oldest bytes of the selected channel |
| pk_avail_o | output | 3 | Valid bytes in pk_bytes_o |
| pk_word_i | input | 32 | Packed word from the packer |
| pk_used_i | input | 3 | Bytes consumed by the packer |
| tx_full_i | input | 1 | Downstream queue full |
| tx_push_o | output | 1 | Push a word downstream |
| tx_ch_o | output | 4 | Channel tag of the pushed word |
| tx_word_o | output | 32 | Word pushed downstream |

## Verification
The hardest case to reach from the ports is a word whose bytes straddle the wrap point of a channel's circular store. Reaching it needs a tail pointer close to the end of the store while fresh bytes have already wrapped to its start. The stimulus fills one channel completely while the output is held full. The bench-side packer then consumes only three bytes per word, so the tail ends at the last slot. A further write lands at the start of the store, and a final four-byte word must join the last old byte with three new ones. Truncation at a full store and a flush colliding with a write are reached the same way, by holding `tx_full_i` high while the stores are filled.

// File: rtl/chan_tx_sched_pkg.sv
package chan_tx_sched_pkg;
  localparam int unsigned WORD_BYTES = 4;
  typedef logic [7:0] byte_t;
  typedef logic [8*WORD_BYTES-1:0] word_t;
endpackage

// File: rtl/chan_tx_rr_pick.sv
module chan_tx_rr_pick #(
  parameter int unsigned N  = 16,
  localparam int unsigned NW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  input  logic [NW-1:0] ptr_i,
  output logic          found_o,
  output logic [NW-1:0] pick_o
);
  // descending scan: smallest offset from ptr_i wins
  always_comb begin
    logic [NW:0] s;
    found_o = 1'b0;
    pick_o  = ptr_i;
    for (int i = N - 1; i >= 0; i--) begin
      s = {1'b0, ptr_i} + (NW+1)'(i);
      if (s >= (NW+1)'(N)) s = s - (NW+1)'(N);
      if (req_i[s[NW-1:0]]) begin
        found_o = 1'b1;
        pick_o  = s[NW-1:0];
      end
    end
  end
endmodule

// File: rtl/chan_tx_buf.sv
module chan_tx_buf
  import chan_tx_sched_pkg::*;
#(
  parameter int unsigned BUF_BYTES = 16,
  localparam int unsigned PW = $clog2(BUF_BYTES),
  localparam int unsigned CW = PW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          wr_en_i,
  input  logic [2:0]    wr_len_i,
  input  word_t         wr_data_i,
  input  logic          rd_en_i,
  input  logic [2:0]    rd_used_i,
  output logic [2:0]    wr_acc_o,
  output logic [CW-1:0] count_o,
  output word_t         rd_bytes_o
);
  byte_t         mem [BUF_BYTES];
  logic [PW-1:0] head_q, tail_q;
  logic [CW-1:0] count_q, cnt_nx, free_w, used_w;
  logic [2:0]    len_c;

  assign len_c  = (wr_len_i > 3'd4) ? 3'd4 : wr_len_i;
  assign free_w = CW'(BUF_BYTES) - count_q;
  always_comb begin
    if (flush_i || !wr_en_i)         wr_acc_o = '0;
    else if (CW'(len_c) > free_w)    wr_acc_o = free_w[2:0];
    else                             wr_acc_o = len_c;
  end
  assign used_w = rd_en_i ? CW'(rd_used_i) : '0;
  assign cnt_nx = count_q + CW'(wr_acc_o) - used_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
      head_q  <= '0;
      tail_q  <= '0;
    end else if (flush_i) begin
      count_q <= '0;
      head_q  <= '0;
      tail_q  <= '0;
    end else begin
      count_q <= cnt_nx;
      if (cnt_nx == '0) begin
        head_q <= '0;
        tail_q <= '0;
      end else begin
        head_q <= head_q + PW'(wr_acc_o);
        tail_q <= tail_q + PW'(used_w);
      end
    end
  end

  always_ff @(posedge clk_i) begin
    for (int k = 0; k < WORD_BYTES; k++)
      if (3'(k) < wr_acc_o) mem[head_q + PW'(k)] <= wr_data_i[8*k +: 8];
  end

  // read span wraps naturally through pointer truncation
  always_comb begin
    for (int k = 0; k < WORD_BYTES; k++)
      rd_bytes_o[8*k +: 8] = mem[tail_q + PW'(k)];
  end

  assign count_o = count_q;
endmodule

// File: rtl/chan_tx_sched.sv
module chan_tx_sched
  import chan_tx_sched_pkg::*;
#(
  parameter int unsigned NUM_CH    = 16,
  parameter int unsigned TXQ_DEPTH = 4,
  localparam int unsigned CHW       = $clog2(NUM_CH),
  localparam int unsigned BUF_BYTES = 4 * TXQ_DEPTH,
  localparam int unsigned CW        = $clog2(BUF_BYTES) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [CHW-1:0]    wr_ch_i,
  input  logic [2:0]        wr_len_i,
  input  logic [31:0]       wr_data_i,
  output logic [2:0]        wr_accept_o,
  input  logic [NUM_CH-1:0] flush_i,
  output logic [NUM_CH-1:0] empty_o,
  output logic [31:0]       pk_bytes_o,
  output logic [2:0]        pk_avail_o,
  input  logic [31:0]       pk_word_i,
  input  logic [2:0]        pk_used_i,
  input  logic              tx_full_i,
  output logic              tx_push_o,
  output logic [CHW-1:0]    tx_ch_o,
  output logic [31:0]       tx_word_o
);
  logic [CW-1:0]     cnt [NUM_CH];
  word_t             rdb [NUM_CH];
  logic [2:0]        acc [NUM_CH];
  logic [NUM_CH-1:0] req;
  logic [CHW-1:0]    ptr_q, pick;
  logic              found;
  logic [CW-1:0]     sel_cnt;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    chan_tx_buf #(.BUF_BYTES(BUF_BYTES)) u_buf (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .flush_i    (flush_i[c]),
      .wr_en_i    (wr_valid_i && (wr_ch_i == CHW'(c))),
      .wr_len_i   (wr_len_i),
      .wr_data_i  (wr_data_i),
      .rd_en_i    (tx_push_o && (pick == CHW'(c))),
      .rd_used_i  (pk_used_i),
      .wr_acc_o   (acc[c]),
      .count_o    (cnt[c]),
      .rd_bytes_o (rdb[c])
    );
    assign req[c]     = (cnt[c] != '0) && !flush_i[c];
    assign empty_o[c] = (cnt[c] == '0);
  end

  chan_tx_rr_pick #(.N(NUM_CH)) u_pick (
    .req_i   (req),
    .ptr_i   (ptr_q),
    .found_o (found),
    .pick_o  (pick)
  );

  assign sel_cnt     = cnt[pick];
  assign pk_bytes_o  = rdb[pick];
  assign pk_avail_o  = !found ? 3'd0 : ((sel_cnt >= CW'(4)) ? 3'd4 : sel_cnt[2:0]);
  assign tx_push_o   = found && !tx_full_i;
  assign tx_ch_o     = pick;
  assign tx_word_o   = pk_word_i;
  assign wr_accept_o = acc[wr_ch_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ptr_q <= '0;
    else if (tx_push_o) ptr_q <= (pick == CHW'(NUM_CH - 1)) ? '0 : pick + 1'b1;
  end
endmodule

// File: rtl/chan_tx_sched_chk.sv
module chan_tx_sched_chk #(
  parameter int unsigned NUM_CH = 16,
  localparam int unsigned CHW   = $clog2(NUM_CH)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_valid_i,
  input logic [2:0]        wr_len_i,
  input logic [2:0]        wr_accept_o,
  input logic [NUM_CH-1:0] flush_i,
  input logic [NUM_CH-1:0] empty_o,
  input logic [2:0]        pk_avail_o,
  input logic              tx_full_i,
  input logic              tx_push_o,
  input logic [CHW-1:0]    tx_ch_o
);
  // R3
  no_push_when_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_full_i |-> !tx_push_o);
  // R5
  push_from_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_push_o |-> (!empty_o[tx_ch_o] && !flush_i[tx_ch_o]));
  // R1
  idle_when_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&empty_o) |-> !tx_push_o);
  // R7
  avail_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_push_o |-> (pk_avail_o != 3'd0 && pk_avail_o <= 3'd4));
  // R2
  accept_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && wr_len_i <= 3'd4) |-> (wr_accept_o <= wr_len_i));
  // R9
  flush_empties_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|flush_i) |=> ((empty_o & $past(flush_i)) == $past(flush_i)));
endmodule

bind chan_tx_sched chan_tx_sched_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_valid_i  (wr_valid_i),
  .wr_len_i    (wr_len_i),
  .wr_accept_o (wr_accept_o),
  .flush_i     (flush_i),
  .empty_o     (empty_o),
  .pk_avail_o  (pk_avail_o),
  .tx_full_i   (tx_full_i),
  .tx_push_o   (tx_push_o),
  .tx_ch_o     (tx_ch_o)
);

// File: tb/sim_chan_tx_sched.sv
module sim_chan_tx_sched;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_valid_i = 1'b0;
  logic [3:0]  wr_ch_i = '0;
  logic [2:0]  wr_len_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [2:0]  wr_accept_o;
  logic [15:0] flush_i = '0;
  logic [15:0] empty_o;
  logic [31:0] pk_bytes_o;
  logic [2:0]  pk_avail_o;
  logic [31:0] pk_word_i;
  logic [2:0]  pk_used_i;
  logic        tx_full_i = 1'b1;
  logic        tx_push_o;
  logic [3:0]  tx_ch_o;
  logic [31:0] tx_word_o;
  logic [2:0]  used_cap = 3'd4;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  function automatic logic [31:0] lane_mask(logic [2:0] n);
    logic [31:0] m = '0;
    for (int k = 0; k < 4; k++) if (3'(k) < n) m[8*k +: 8] = 8'hFF;
    return m;
  endfunction

  // bench-side packer: consumes up to used_cap bytes, passes them through
  assign pk_used_i = (pk_avail_o < used_cap) ? pk_avail_o : used_cap;
  assign pk_word_i = pk_bytes_o & lane_mask(pk_used_i);

  chan_tx_sched u0 (
    .clk_i(clk), .rst_ni(rst_ni), .wr_valid_i(wr_valid_i), .wr_ch_i(wr_ch_i),
    .wr_len_i(wr_len_i), .wr_data_i(wr_data_i), .wr_accept_o(wr_accept_o),
    .flush_i(flush_i), .empty_o(empty_o), .pk_bytes_o(pk_bytes_o),
    .pk_avail_o(pk_avail_o), .pk_word_i(pk_word_i), .pk_used_i(pk_used_i),
    .tx_full_i(tx_full_i), .tx_push_o(tx_push_o), .tx_ch_o(tx_ch_o),
    .tx_word_o(tx_word_o)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // {channel, length, data, expected accept}
  localparam logic [41:0] VEC [13] = '{
    {4'd3,  3'd4, 32'h44332211, 3'd4},
    {4'd3,  3'd4, 32'h88776655, 3'd4},
    {4'd3,  3'd4, 32'hCCBBAA99, 3'd4},
    {4'd3,  3'd4, 32'hF0E0D0C0, 3'd4},
    {4'd3,  3'd2, 32'h12345678, 3'd0},
    {4'd0,  3'd3, 32'hDDCCBBAA, 3'd3},
    {4'd15, 3'd1, 32'hAABBCCEE, 3'd1},
    {4'd7,  3'd4, 32'h77665544, 3'd4},
    {4'd11, 3'd4, 32'hB3B2B1B0, 3'd4},
    {4'd11, 3'd4, 32'hB7B6B5B4, 3'd4},
    {4'd11, 3'd4, 32'hBBBAB9B8, 3'd4},
    {4'd11, 3'd3, 32'hFFBEBDBC, 3'd3},
    {4'd11, 3'd4, 32'hC3C2C1C0, 3'd1}
  };
  // {channel, avail, word} in expected push order
  localparam logic [38:0] DRN [11] = '{
    {4'd0,  3'd3, 32'h00CCBBAA},
    {4'd3,  3'd4, 32'h44332211},
    {4'd7,  3'd4, 32'h77665544},
    {4'd11, 3'd4, 32'hB3B2B1B0},
    {4'd15, 3'd1, 32'h000000EE},
    {4'd3,  3'd4, 32'h88776655},
    {4'd11, 3'd4, 32'hB7B6B5B4},
    {4'd3,  3'd4, 32'hCCBBAA99},
    {4'd11, 3'd4, 32'hBBBAB9B8},
    {4'd3,  3'd4, 32'hF0E0D0C0},
    {4'd11, 3'd4, 32'hC0BEBDBC}
  };
  localparam logic [31:0] WRAP_W [5] = '{
    32'h00030201, 32'h00060504, 32'h00090807, 32'h000C0B0A, 32'h000F0E0D
  };

  task automatic put(logic [3:0] ch, logic [2:0] len, logic [31:0] d);
    wr_valid_i = 1'b1; wr_ch_i = ch; wr_len_i = len; wr_data_i = d;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (2) @(negedge clk);
    #2 chk("R1 empty in reset", 32'(empty_o), 32'h0000FFFF);
    @(negedge clk) rst_ni = 1'b1;
    #2 chk("R1 empty after reset", 32'(empty_o), 32'h0000FFFF);
    chk("R1 no push after reset", 32'(tx_push_o), 32'd0);

    // R2 table: writes with output held full
    for (int i = 0; i < 13; i++) begin
      @(negedge clk);
      put(VEC[i][41:38], VEC[i][37:35], VEC[i][34:3]);
      #2 chk($sformatf("R2 accept row %0d", i), 32'(wr_accept_o), 32'(VEC[i][2:0]));
      chk("R3 no push while full", 32'(tx_push_o), 32'd0);
    end
    @(negedge clk) wr_valid_i = 1'b0;
    #2 chk("R8 empty flags after fill", 32'(empty_o), 32'h0000FFFF & ~32'h00008889);

    // R4 R5 R10 drain in rotation order
    tx_full_i = 1'b0;
    for (int i = 0; i < 11; i++) begin
      #2 chk($sformatf("R10 push %0d", i), 32'(tx_push_o), 32'd1);
      chk($sformatf("R4 R5 channel %0d", i), 32'(tx_ch_o), 32'(DRN[i][38:35]));
      chk($sformatf("R7 avail %0d", i), 32'(pk_avail_o), 32'(DRN[i][34:32]));
      chk($sformatf("R10 word %0d", i), tx_word_o, DRN[i][31:0]);
      @(negedge clk);
    end
    #2 chk("R5 idle when all empty", 32'(tx_push_o), 32'd0);
    chk("R8 all empty after drain", 32'(empty_o), 32'h0000FFFF);

    // R6 straddle: fill ch5, drain three bytes per word
    tx_full_i = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      put(4'd5, 3'd4, {8'(4*i+4), 8'(4*i+3), 8'(4*i+2), 8'(4*i+1)});
    end
    @(negedge clk) wr_valid_i = 1'b0; used_cap = 3'd3; tx_full_i = 1'b0;
    for (int i = 0; i < 5; i++) begin
      #2 chk($sformatf("R7 partial word %0d", i), tx_word_o, WRAP_W[i]);
      @(negedge clk);
    end
    tx_full_i = 1'b1;
    put(4'd5, 3'd4, 32'h14131211);
    #2 chk("R7 one byte left", 32'(pk_avail_o), 32'd1);
    chk("R2 accept after wrap", 32'(wr_accept_o), 32'd4);
    @(negedge clk) wr_valid_i = 1'b0; used_cap = 3'd4; tx_full_i = 1'b0;
    #2 chk("R6 straddling word", tx_word_o, 32'h13121110);
    chk("R6 straddle avail", 32'(pk_avail_o), 32'd4);
    @(negedge clk);
    #2 chk("R6 final byte", tx_word_o, 32'h00000014);
    @(negedge clk);
    #2 chk("R8 ch5 empty", 32'(empty_o[5]), 32'd1);
    chk("R5 idle", 32'(tx_push_o), 32'd0);

    // R9 flush against a same-cycle write
    tx_full_i = 1'b1;
    @(negedge clk) put(4'd2, 3'd4, 32'hA3A2A1A0);
    @(negedge clk) put(4'd9, 3'd4, 32'h93929190);
    @(negedge clk) put(4'd2, 3'd4, 32'h5A5A5A5A); flush_i = 16'h0004; tx_full_i = 1'b0;
    #2 chk("R9 write under flush accepts 0", 32'(wr_accept_o), 32'd0);
    chk("R9 flushed channel skipped", 32'(tx_ch_o), 32'd9);
    chk("R10 word ch9", tx_word_o, 32'h93929190);
    @(negedge clk) wr_valid_i = 1'b0; flush_i = '0;
    #2 chk("R9 ch2 empty after flush", 32'(empty_o[2]), 32'd1);
    chk("R9 nothing left to send", 32'(tx_push_o), 32'd0);
    chk("R8 all empty at end", 32'(empty_o), 32'h0000FFFF);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule